// File: doc/BRIEF.md
# Interpreter Operand Decoder

This block decodes one operand of a bytecode interpreter in hardware. A start pulse hands it the current code-ROM read pointer and the operand size flag. It pulls the encoded operand bytes one at a time over a byte-serial code-ROM handshake and forms the effective address. Where needed, it reads an index word and the operand value from a 256-byte scratchpad over a second byte handshake. It ends with a one-cycle done pulse, with the address and value held on its result outputs.

The size flag is a cached copy of one status bit, and the core supplies it on each start. The decoder does all the address work in every case. For three cases it stops short of the value read and returns a trap code, so that a software routine can finish the job: an indirect operand, an operand in video memory, and the special address 0x837D. Video memory itself is never touched.

Top module: `operand_decoder`

## Requirements
- R1: After reset, done_o, trap_o, code_req_o, sp_req_o, addr_o and value_o are all zero.
- R2: A first byte with bit 7 clear is a short operand. Its address is 0x8300 plus bits 6:0, and exactly one code byte is consumed.
- R3: A first byte with bit 7 set is a long operand. Bit 6 marks video memory, bit 5 marks indirection and bit 4 marks indexing. If bits 3:0 are not 0xF, they form the upper nibble of a 12-bit address whose low byte is the next code byte. The address is 0x8300 plus that 12-bit value.
- R4: In a long operand with bits 3:0 equal to 0xF, the next two code bytes, high byte first, form a 16-bit value. The address is 0x8300 plus that value, modulo 2^16.
- R5: With the index bit set, one more code byte k follows the address bytes. The scratchpad bytes at k (high) and k+1 modulo 256 (low) form a word, and that word is added to the address modulo 2^16.
- R6: Code bytes are read from consecutive addresses starting at code_base_i as sampled on the start cycle. Later changes of code_base_i have no effect, and the number of bytes read equals the operand length.
- R7: With word_i low, the value is the scratchpad byte at address bits 7:0, zero-extended. With word_i high, the value is the byte at bits 7:0 (high) followed by the byte at bits 7:0 plus 1 modulo 256 (low), for even or odd addresses.
- R8: The trap code is 3 for indirection, else 2 for video memory, else 1 for address 0x837D, else 0. The address is still reported. On a trap no value read is made and value_o is zero.
- R9: done_o is high for exactly one cycle per operand. trap_o is zero whenever done_o is low.
- R10: A request stays high, with its address stable, until it is acknowledged. The two request outputs are never high together.
- R11: A start pulse that arrives while an operand is being decoded is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin decoding one operand |
| word_i | input | 1 | Operand size: 1 word, 0 byte |
| code_base_i | input | 16 | Code-ROM read pointer at start |
| code_req_o | output | 1 | Code-ROM byte read request |
| code_addr_o | output | 16 | Code-ROM byte address |
| code_ack_i | input | 1 | Code-ROM read acknowledge, data valid |
| code_data_i | input | 8 | Code-ROM read data |
| sp_req_o | output | 1 | Scratchpad byte read request |
| sp_addr_o | output | 8 | Scratchpad byte address |
| sp_ack_i | input | 1 | Scratchpad read acknowledge, data valid |
| sp_data_i | input | 8 | Scratchpad read data |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 2 | Completion code, valid with done_o |
| addr_o | output | 16 | Effective operand address |
| value_o | output | 16 | Operand value |

## Verification
The assertions assume that both acknowledge inputs rise only while their own request is high, and only once per request. They also assume the data inputs are valid in the acknowledge cycle. The bench memory models respond on the falling edge and only to a pending request, with a latency of zero to two cycles that varies between operands. Each model gives at most one acknowledge per request before it sees the request drop, so the handshake stays within those assumptions. Start pulses are sent only to an idle decoder, except in the one deliberate test where a start arrives mid-operand.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_B0, ST_LA, ST_LB, ST_IX, ST_IH, ST_IL, ST_CHK, ST_VH, ST_VL, ST_DONE
  } opdec_state_e;

  typedef struct packed {
    logic       long_f;
    logic       vid;
    logic       ind;
    logic       idx;
    logic [3:0] nib;
    logic [6:0] off;
  } opdec_spec_t;

  localparam logic [1:0] TRAP_NONE  = 2'd0;
  localparam logic [1:0] TRAP_MAGIC = 2'd1;
  localparam logic [1:0] TRAP_VID   = 2'd2;
  localparam logic [1:0] TRAP_IND   = 2'd3;
endpackage

// File: rtl/opdec_spec_decode.sv
module opdec_spec_decode
  import opdec_pkg::*;
(
  input  logic [7:0]  byte_i,
  output opdec_spec_t spec_o
);
  always_comb begin
    spec_o.long_f = byte_i[7];
    // flags only meaningful in long form
    spec_o.vid    = byte_i[7] & byte_i[6];
    spec_o.ind    = byte_i[7] & byte_i[5];
    spec_o.idx    = byte_i[7] & byte_i[4];
    spec_o.nib    = byte_i[3:0];
    spec_o.off    = byte_i[6:0];
  end
endmodule

// File: rtl/opdec_trap_sel.sv
module opdec_trap_sel
  import opdec_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] MAGIC = 16'h837D
) (
  input  logic          ind_i,
  input  logic          vid_i,
  input  logic [AW-1:0] ea_i,
  output logic [1:0]    code_o
);
  always_comb begin
    if (ind_i)              code_o = TRAP_IND;
    else if (vid_i)         code_o = TRAP_VID;
    else if (ea_i == MAGIC) code_o = TRAP_MAGIC;
    else                    code_o = TRAP_NONE;
  end
endmodule

// File: rtl/operand_decoder.sv
module operand_decoder
  import opdec_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned SP_AW = 8,
  parameter logic [AW-1:0] SP_BASE = 16'h8300,
  parameter logic [AW-1:0] MAGIC = 16'h837D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             word_i,
  input  logic [AW-1:0]    code_base_i,
  output logic             code_req_o,
  output logic [AW-1:0]    code_addr_o,
  input  logic             code_ack_i,
  input  logic [7:0]       code_data_i,
  output logic             sp_req_o,
  output logic [SP_AW-1:0] sp_addr_o,
  input  logic             sp_ack_i,
  input  logic [7:0]       sp_data_i,
  output logic             done_o,
  output logic [1:0]       trap_o,
  output logic [AW-1:0]    addr_o,
  output logic [15:0]      value_o
);
  localparam logic [3:0] LONG_ESC = 4'hF;
  localparam int unsigned PAD12 = AW - 12;
  localparam int unsigned PAD16 = AW - 16;

  opdec_state_e     state_q;
  opdec_spec_t      spec_q, spec_c;
  logic [AW-1:0]    ptr_q, ea_q;
  logic [15:0]      val_q;
  logic [7:0]       hi_q;
  logic [SP_AW-1:0] ix_q;
  logic             wide_q;
  logic [1:0]       trap_q, trap_c;

  opdec_spec_decode u_spec (
    .byte_i (code_data_i),
    .spec_o (spec_c)
  );

  opdec_trap_sel #(.AW(AW), .MAGIC(MAGIC)) u_trap (
    .ind_i  (spec_q.ind),
    .vid_i  (spec_q.vid),
    .ea_i   (ea_q),
    .code_o (trap_c)
  );

  always_comb begin
    code_req_o = (state_q == ST_B0) || (state_q == ST_LA) ||
                 (state_q == ST_LB) || (state_q == ST_IX);
    sp_req_o   = (state_q == ST_IH) || (state_q == ST_IL) ||
                 (state_q == ST_VH) || (state_q == ST_VL);
    code_addr_o = ptr_q;
    unique case (state_q)
      ST_IH:   sp_addr_o = ix_q;
      ST_IL:   sp_addr_o = ix_q + SP_AW'(1);
      ST_VL:   sp_addr_o = ea_q[SP_AW-1:0] + SP_AW'(wide_q);
      default: sp_addr_o = ea_q[SP_AW-1:0];
    endcase
  end

  assign done_o  = (state_q == ST_DONE);
  assign trap_o  = done_o ? trap_q : TRAP_NONE;
  assign addr_o  = ea_q;
  assign value_o = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      spec_q  <= '0;
      ptr_q   <= '0;
      ea_q    <= '0;
      val_q   <= '0;
      hi_q    <= '0;
      ix_q    <= '0;
      wide_q  <= 1'b0;
      trap_q  <= TRAP_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ptr_q   <= code_base_i;
          wide_q  <= word_i;
          val_q   <= '0;
          trap_q  <= TRAP_NONE;
          spec_q  <= '0;
          state_q <= ST_B0;
        end
        ST_B0: if (code_ack_i) begin
          ptr_q  <= ptr_q + AW'(1);
          spec_q <= spec_c;
          if (!spec_c.long_f) begin
            ea_q    <= SP_BASE + AW'(spec_c.off);
            state_q <= ST_CHK;
          end else begin
            state_q <= ST_LA;
          end
        end
        ST_LA: if (code_ack_i) begin
          ptr_q <= ptr_q + AW'(1);
          if (spec_q.nib == LONG_ESC) begin
            hi_q    <= code_data_i;
            state_q <= ST_LB;
          end else begin
            ea_q    <= SP_BASE + {{PAD12{1'b0}}, spec_q.nib, code_data_i};
            state_q <= spec_q.idx ? ST_IX : ST_CHK;
          end
        end
        ST_LB: if (code_ack_i) begin
          ptr_q   <= ptr_q + AW'(1);
          ea_q    <= SP_BASE + {{PAD16{1'b0}}, hi_q, code_data_i};
          state_q <= spec_q.idx ? ST_IX : ST_CHK;
        end
        ST_IX: if (code_ack_i) begin
          ptr_q   <= ptr_q + AW'(1);
          ix_q    <= code_data_i[SP_AW-1:0];
          state_q <= ST_IH;
        end
        ST_IH: if (sp_ack_i) begin
          hi_q    <= sp_data_i;
          state_q <= ST_IL;
        end
        ST_IL: if (sp_ack_i) begin
          ea_q    <= ea_q + {{PAD16{1'b0}}, hi_q, sp_data_i};
          state_q <= ST_CHK;
        end
        ST_CHK: begin
          trap_q <= trap_c;
          if (trap_c != TRAP_NONE) state_q <= ST_DONE;
          else                     state_q <= wide_q ? ST_VH : ST_VL;
        end
        ST_VH: if (sp_ack_i) begin
          val_q[15:8] <= sp_data_i;
          state_q     <= ST_VL;
        end
        ST_VL: if (sp_ack_i) begin
          val_q[7:0] <= sp_data_i;
          state_q    <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/operand_decoder_chk.sv
module operand_decoder_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned SP_AW = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             code_req_o,
  input logic [AW-1:0]    code_addr_o,
  input logic             code_ack_i,
  input logic             sp_req_o,
  input logic [SP_AW-1:0] sp_addr_o,
  input logic             sp_ack_i,
  input logic             done_o,
  input logic [1:0]       trap_o,
  input logic [15:0]      value_o
);
  p_no_dual_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(code_req_o && sp_req_o));

  p_code_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_req_o && !code_ack_i |=> code_req_o && $stable(code_addr_o));

  p_sp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_req_o && !sp_ack_i |=> sp_req_o && $stable(sp_addr_o));

  p_code_seq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_req_o && code_ack_i |=> !code_req_o || (code_addr_o == $past(code_addr_o) + AW'(1)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_trap_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> trap_o == 2'd0);

  p_idle_after_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !code_req_o && !sp_req_o);

  p_trap_noval_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && trap_o != 2'd0 |-> value_o == 16'h0000);
endmodule

bind operand_decoder operand_decoder_chk #(.AW(AW), .SP_AW(SP_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .code_req_o  (code_req_o),
  .code_addr_o (code_addr_o),
  .code_ack_i  (code_ack_i),
  .sp_req_o    (sp_req_o),
  .sp_addr_o   (sp_addr_o),
  .sp_ack_i    (sp_ack_i),
  .done_o      (done_o),
  .trap_o      (trap_o),
  .value_o     (value_o)
);

// File: tb/operand_decoder_test.sv
module operand_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        word = 1'b0;
  logic [15:0] code_base = '0;
  logic        code_req, code_ack, sp_req, sp_ack, done;
  logic [15:0] code_addr, addr, value;
  logic [7:0]  code_data, sp_data, sp_addr;
  logic [1:0]  trap;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  operand_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_i(word),
    .code_base_i(code_base), .code_req_o(code_req), .code_addr_o(code_addr),
    .code_ack_i(code_ack), .code_data_i(code_data), .sp_req_o(sp_req),
    .sp_addr_o(sp_addr), .sp_ack_i(sp_ack), .sp_data_i(sp_data),
    .done_o(done), .trap_o(trap), .addr_o(addr), .value_o(value)
  );

  function automatic logic [7:0] spf(input logic [7:0] x);
    return x * 8'd29 + 8'd7;
  endfunction

  // code ROM model
  logic [7:0]  gb [4];
  logic [15:0] g_base = '0;
  int          lat = 0;
  int          g_wait = 0, g_cnt = 0, g_oob = 0;
  logic [15:0] g_off;
  initial begin code_ack = 1'b0; code_data = '0; end
  always @(negedge clk) begin
    code_ack <= 1'b0;
    if (rst_n && code_req && !code_ack) begin
      if (g_wait >= lat) begin
        g_off = code_addr - g_base;
        code_ack  <= 1'b1;
        code_data <= (g_off < 16'd4) ? gb[g_off[1:0]] : 8'h00;
        if (g_off >= 16'd4) g_oob <= g_oob + 1;
        g_cnt  <= g_cnt + 1;
        g_wait <= 0;
      end else g_wait <= g_wait + 1;
    end
  end

  // scratchpad model
  int s_wait = 0, s_cnt = 0, d_cnt = 0;
  initial begin sp_ack = 1'b0; sp_data = '0; end
  always @(negedge clk) begin
    sp_ack <= 1'b0;
    if (rst_n && sp_req && !sp_ack) begin
      if (s_wait >= lat) begin
        sp_ack  <= 1'b1;
        sp_data <= spf(sp_addr);
        s_cnt   <= s_cnt + 1;
        s_wait  <= 0;
      end else s_wait <= s_wait + 1;
    end
    if (done) d_cnt <= d_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic predict(input logic [7:0] b0, b1, b2, b3, input logic w,
                         output int len, output int sreads, output logic [15:0] ea,
                         output logic [15:0] val, output logic [1:0] tc);
    logic vid = 1'b0, ind = 1'b0, idx = 1'b0;
    logic [15:0] d;
    logic [7:0] k;
    if (!b0[7]) begin
      ea = 16'h8300 + {9'd0, b0[6:0]};
      len = 1; k = 8'h00;
    end else begin
      vid = b0[6]; ind = b0[5]; idx = b0[4];
      if (b0[3:0] == 4'hF) begin d = {b1, b2}; len = 3; k = b3; end
      else begin d = {4'h0, b0[3:0], b1}; len = 2; k = b2; end
      ea = d + 16'h8300;
      if (idx) begin
        len++;
        ea = ea + {spf(k), spf(k + 8'd1)};
      end
    end
    tc = ind ? 2'd3 : vid ? 2'd2 : (ea == 16'h837D) ? 2'd1 : 2'd0;
    sreads = (idx ? 2 : 0) + ((tc != 2'd0) ? 0 : (w ? 2 : 1));
    if (tc != 2'd0) val = 16'h0000;
    else if (w) val = {spf(ea[7:0]), spf(ea[7:0] + 8'd1)};
    else val = {8'h00, spf(ea[7:0])};
  endtask

  int opn = 0;

  task automatic do_op(input logic [7:0] b0, b1, b2, b3, input logic w,
                       input string tag, input bit poke);
    int len, sr, g0, o0, s0, dc0, cyc;
    logic [15:0] ea, val;
    logic [1:0] tc;
    predict(b0, b1, b2, b3, w, len, sr, ea, val, tc);
    opn++;
    lat = poke ? 2 : opn % 3;
    gb[0] = b0; gb[1] = b1; gb[2] = b2; gb[3] = b3;
    g_base = 16'h6000 + 16'(opn * 5);
    code_base = g_base;
    word = w;
    g0 = g_cnt; o0 = g_oob; s0 = s_cnt; dc0 = d_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    code_base = ~g_base;  // R6: later base changes ignored
    if (poke) begin
      @(negedge clk) begin start = 1'b1; word = ~w; end
      @(negedge clk) start = 1'b0;  // R11: mid-operand start
    end
    cyc = 0;
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    check(done, "R9 done timeout", 32'(cyc), 32'd400);
    check(addr == ea, tag, 32'(addr), 32'(ea));
    check(value == val, "R7", 32'(value), 32'(val));
    check(trap == tc, "R8", 32'(trap), 32'(tc));
    @(negedge clk);
    check(!done, "R9 pulse", 32'(done), 32'd0);
    check(trap == 2'd0, "R9 quiet", 32'(trap), 32'd0);
    check(g_cnt - g0 == len, "R6 length", 32'(g_cnt - g0), 32'(len));
    check(g_oob == o0, "R6 address", 32'(g_oob - o0), 32'd0);
    check(s_cnt - s0 == sr, "R8 reads", 32'(s_cnt - s0), 32'(sr));
    check(d_cnt - dc0 == 1, poke ? "R11" : "R9 count", 32'(d_cnt - dc0), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] l12 [4];
    logic [15:0] l16 [6];
    l12[0] = 8'h00; l12[1] = 8'h7D; l12[2] = 8'hA5; l12[3] = 8'hFF;
    l16[0] = 16'h0000; l16[1] = 16'h007D; l16[2] = 16'h7D00;
    l16[3] = 16'hFFFF; l16[4] = 16'h1234; l16[5] = 16'h7CFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && trap == 2'd0 && !code_req && !sp_req, "R1 ctrl",
          {28'd0, done, trap, code_req | sp_req}, 32'd0);
    check(addr == 16'h0 && value == 16'h0, "R1 data", {addr, value}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int o = 0; o < 128; o++)
      for (int w = 0; w < 2; w++)
        do_op({1'b0, 7'(o)}, 8'h00, 8'h00, 8'h00, w[0], "R2", 1'b0);
    for (int n = 0; n < 15; n++)
      for (int j = 0; j < 4; j++)
        do_op({4'h8, 4'(n)}, l12[j], 8'h00, 8'h00, j[0], "R3", 1'b0);
    for (int j = 0; j < 6; j++)
      for (int w = 0; w < 2; w++)
        do_op(8'h8F, l16[j][15:8], l16[j][7:0], 8'h00, w[0], "R4", 1'b0);
    for (int k = 0; k < 256; k++)
      do_op(8'h90, 8'h10, 8'(k), 8'h00, k[0], "R5", 1'b0);
    do_op(8'h9F, 8'h00, 8'h00, 8'hFF, 1'b1, "R5", 1'b0);
    do_op(8'h9F, 8'hFF, 8'h80, 8'h42, 1'b0, "R5", 1'b0);
    for (int f = 0; f < 8; f++)
      do_op({1'b1, 3'(f), 4'h0}, 8'h7D, 8'h03, 8'h00, f[0], "R8", 1'b0);
    do_op(8'hBF, 8'h00, 8'h7D, 8'h05, 1'b1, "R8", 1'b0);
    do_op(8'h9F, 8'h12, 8'h34, 8'h56, 1'b1, "R11", 1'b1);
    do_op(8'h91, 8'h7D, 8'hFF, 8'h00, 1'b0, "R11", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule